// File: doc/BRIEF.md
# Clock Generator Strap Capture and Mode Decoder

This block sits at the front of a clock generator. After reset it waits for the supply to be reported good. It then runs a settle delay of a programmed number of cycles. Next it waits for an active-low power-good level and, on the first cycle that level is seen low, captures the mode and frequency straps and the current-multiplier strap. From then on the captured values are frozen until the next reset, and the block reports that the clock outputs are running.

The captured straps are decoded into a CPU frequency code and a source select for the external 66 MHz input. They also give a flag that puts every output into high impedance and a flag for combinations that are not defined. The high-order strap has three levels, presented as a 2-bit code.

In the test mode the block produces the output-group clocks from a test clock that is sampled in the system clock domain. Every group uses a fixed ratio. All the ratios come from one shared down-counter, so the rising edges of the groups line up.

Top module: `clkgen_strap_ctrl`

## Requirements
- R1: After reset, seq_state is 0, outs_on is 0, and every latched strap, cpu_mhz, ext66_sel, tristate_all, reserved_flag and every tck_* output is 0.
- R2: seq_state stays 0 (wait for supply) until supply_ok is 1. It then stays at 1 (settle) for exactly SETTLE_CYC cycles, and then moves to 2 (sample).
- R3: In state 2, a cycle with pg_n low captures s_lo, s_hi and mult_sel and moves to state 3 (running, outs_on = 1) at the next edge. While pg_n stays high, the state stays at 2.
- R4: Once state 3 is reached, changes on pg_n, s_lo, s_hi and mult_sel have no effect on the latched values, on the decoded outputs or on the state until reset.
- R5: pg_n low during states 0 or 1 captures nothing. The values captured are those present in the sample state.
- R6: With s_hi code 00 (low) or 10 (high), cpu_mhz shows 66, 100, 200 or 133 for s_lo = 00, 01, 10 or 11. In every other mode it shows 0.
- R7: ext66_sel is 1 only for s_hi code 10 (high level: the 66 MHz group follows the external input and PCI is that input divided by 2). For code 00 the internal source is used and ext66_sel is 0.
- R8: s_hi code 01 (mid) with s_lo = 00 raises tristate_all with reserved_flag low.
- R9: s_hi code 01 with s_lo[1] = 1, or s_hi code 11 (illegal level) with any s_lo, raises both tristate_all and reserved_flag.
- R10: s_hi code 01 with s_lo = 01 is test mode. tck_ref follows the test clock, tck_cpu and tck_48 run at 1/2, tck_66 at 1/4 and tck_pci at 1/8 of its rate. In every other mode all tck_* outputs stay 0.
- R11: In test mode, every rising edge of tck_pci falls in the same cycle as a rising edge of tck_66 and of tck_cpu.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply reported stable |
| pg_n | input | 1 | Power-good level, active low |
| s_lo | input | 2 | Frequency select straps |
| s_hi | input | 2 | Three-level mode strap: 00 low, 01 mid, 10 high, 11 illegal |
| mult_sel | input | 1 | Current multiplier strap |
| tclk_in | input | 1 | Test clock, sampled in clk domain |
| seq_state | output | 2 | 0 wait, 1 settle, 2 sample, 3 running |
| outs_on | output | 1 | Outputs running |
| lat_s_lo | output | 2 | Captured frequency straps |
| lat_s_hi | output | 2 | Captured mode strap |
| lat_mult | output | 1 | Captured multiplier strap |
| cpu_mhz | output | 8 | CPU frequency code in MHz, 0 when not normal |
| ext66_sel | output | 1 | 66 MHz group sourced from external input |
| tristate_all | output | 1 | All outputs to high impedance |
| reserved_flag | output | 1 | Undefined strap combination captured |
| tck_ref | output | 1 | Test clock divided by 1 |
| tck_cpu | output | 1 | Test clock divided by 2 |
| tck_48 | output | 1 | Test clock divided by 2 |
| tck_66 | output | 1 | Test clock divided by 4 |
| tck_pci | output | 1 | Test clock divided by 8 |

## Verification
The bench builds the block with SETTLE_CYC set to 6 instead of the default that matches a 0.2 ms delay at 50 MHz. That makes the settle window short enough to count its exact length on every power-up, once for each strap combination. The test clock runs at one eighth of the system clock, so a 512-cycle window holds about 64 reference edges and 8 edges of the slowest group. That is enough to compare the ratios and check edge alignment in each test-mode pass.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_t;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;
  localparam logic [1:0] LVL_BAD  = 2'b11;

  localparam int TDIV_STAGES = 3;
endpackage

// File: rtl/clkgen_seq.sv
`timescale 1ns/1ps
module clkgen_seq
  import clkgen_pkg::*;
#(
  parameter int SETTLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pg_n,
  output seq_t state,
  output logic sample_en
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_t             state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d   = state;
    cnt_d     = '0;
    cnt_en    = 1'b0;
    sample_en = 1'b0;
    case (state)
      ST_WAIT: begin
        cnt_en = 1'b1;
        if (supply_ok) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) state_d = ST_SAMPLE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_SAMPLE: begin
        if (!pg_n) begin
          sample_en = 1'b1;
          state_d   = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAIT;
      cnt_q <= '0;
    end else begin
      state <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/clkgen_strap.sv
`timescale 1ns/1ps
module clkgen_strap
  import clkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       on,
  input  logic [1:0] s_lo,
  input  logic [1:0] s_hi,
  input  logic       mult_sel,
  output logic [1:0] lat_s_lo,
  output logic [1:0] lat_s_hi,
  output logic       lat_mult,
  output logic [7:0] cpu_mhz,
  output logic       ext66_sel,
  output logic       tristate_all,
  output logic       reserved_flag,
  output logic       test_mode
);
  logic       is_mid, is_bad, is_test, is_rsv, is_tri;
  logic [7:0] freq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_s_lo <= '0;
      lat_s_hi <= '0;
      lat_mult <= 1'b0;
    end else if (sample_en) begin
      lat_s_lo <= s_lo;
      lat_s_hi <= s_hi;
      lat_mult <= mult_sel;
    end
  end

  always_comb begin
    is_mid  = (lat_s_hi == LVL_MID);
    is_bad  = (lat_s_hi == LVL_BAD);
    is_test = is_mid && (lat_s_lo == 2'b01);
    is_rsv  = is_bad || (is_mid && lat_s_lo[1]);
    is_tri  = is_bad || (is_mid && !is_test);
    case (lat_s_lo)
      2'b00:   freq = 8'd66;
      2'b01:   freq = 8'd100;
      2'b10:   freq = 8'd200;
      default: freq = 8'd133;
    endcase
    cpu_mhz       = (on && !is_mid && !is_bad) ? freq : 8'd0;
    ext66_sel     = on && (lat_s_hi == LVL_HIGH);
    tristate_all  = on && is_tri;
    reserved_flag = on && is_rsv;
    test_mode     = on && is_test;
  end
endmodule

// File: rtl/clkgen_tdiv.sv
`timescale 1ns/1ps
module clkgen_tdiv #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tclk_in,
  output logic              ref_q,
  output logic [STAGES-1:0] div_q
);
  logic [2:0]        sync_q;
  logic              rise;
  logic [STAGES-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    rise   = sync_q[1] && !sync_q[2];
    cnt_en = !run || rise;
    cnt_d  = run ? (div_q - 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      ref_q  <= 1'b0;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], tclk_in};
      ref_q  <= run && sync_q[1];
      if (cnt_en) div_q <= cnt_d;
    end
  end
endmodule

// File: rtl/clkgen_strap_ctrl.sv
`timescale 1ns/1ps
module clkgen_strap_ctrl
  import clkgen_pkg::*;
#(
  parameter int SETTLE_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pg_n,
  input  logic [1:0] s_lo,
  input  logic [1:0] s_hi,
  input  logic       mult_sel,
  input  logic       tclk_in,
  output logic [1:0] seq_state,
  output logic       outs_on,
  output logic [1:0] lat_s_lo,
  output logic [1:0] lat_s_hi,
  output logic       lat_mult,
  output logic [7:0] cpu_mhz,
  output logic       ext66_sel,
  output logic       tristate_all,
  output logic       reserved_flag,
  output logic       tck_ref,
  output logic       tck_cpu,
  output logic       tck_48,
  output logic       tck_66,
  output logic       tck_pci
);
  seq_t                   state;
  logic                   sample_en;
  logic                   test_mode;
  logic [TDIV_STAGES-1:0] div_q;

  clkgen_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pg_n(pg_n),
    .state(state), .sample_en(sample_en)
  );

  assign seq_state = state;
  assign outs_on   = (state == ST_RUN);

  clkgen_strap u_strap (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .on(outs_on),
    .s_lo(s_lo), .s_hi(s_hi), .mult_sel(mult_sel),
    .lat_s_lo(lat_s_lo), .lat_s_hi(lat_s_hi), .lat_mult(lat_mult),
    .cpu_mhz(cpu_mhz), .ext66_sel(ext66_sel), .tristate_all(tristate_all),
    .reserved_flag(reserved_flag), .test_mode(test_mode)
  );

  clkgen_tdiv #(.STAGES(TDIV_STAGES)) u_tdiv (
    .clk(clk), .rst_n(rst_n), .run(test_mode), .tclk_in(tclk_in),
    .ref_q(tck_ref), .div_q(div_q)
  );

  assign tck_cpu = div_q[0];
  assign tck_48  = div_q[0];
  assign tck_66  = div_q[1];
  assign tck_pci = div_q[2];
endmodule

// File: rtl/clkgen_chk.sv
`timescale 1ns/1ps
module clkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       pg_n,
  input logic [1:0] seq_state,
  input logic       outs_on,
  input logic [1:0] lat_s_lo,
  input logic [1:0] lat_s_hi,
  input logic       lat_mult,
  input logic [7:0] cpu_mhz,
  input logic       tristate_all,
  input logic       reserved_flag,
  input logic       tck_ref,
  input logic       tck_cpu,
  input logic       tck_66,
  input logic       tck_pci
);
  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd0 && !supply_ok) |=> (seq_state == 2'd0));

  // R3
  sample_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd2 && !pg_n) |=> (seq_state == 2'd3));

  // R3
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd2 && pg_n) |=> (seq_state == 2'd2));

  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd3) |=> (seq_state == 2'd3 && $stable(lat_s_lo)
                             && $stable(lat_s_hi) && $stable(lat_mult)));

  // R9
  rsv_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_flag |-> tristate_all);

  // R6
  tri_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tristate_all |-> (cpu_mhz == 8'd0));

  // R10
  idle_tck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outs_on |-> !(tck_ref || tck_cpu || tck_66 || tck_pci));

  // R11
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck_pci) |-> ($rose(tck_66) && $rose(tck_cpu)));
endmodule

bind clkgen_strap_ctrl clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pg_n(pg_n),
  .seq_state(seq_state), .outs_on(outs_on), .lat_s_lo(lat_s_lo),
  .lat_s_hi(lat_s_hi), .lat_mult(lat_mult), .cpu_mhz(cpu_mhz),
  .tristate_all(tristate_all), .reserved_flag(reserved_flag),
  .tck_ref(tck_ref), .tck_cpu(tck_cpu), .tck_66(tck_66), .tck_pci(tck_pci)
);

// File: tb/clkgen_strap_ctrl_tb.sv
`timescale 1ns/1ps
module clkgen_strap_ctrl_tb;
  localparam int SETTLE = 6;
  localparam int NVEC = 11;
  // {s_hi, s_lo, mult, cpu_mhz, ext, tri, rsv, test}
  localparam logic [16:0] VEC [NVEC] = '{
    {2'b00, 2'b00, 1'b0, 8'd66,  4'b0000},
    {2'b00, 2'b01, 1'b1, 8'd100, 4'b0000},
    {2'b00, 2'b10, 1'b0, 8'd200, 4'b0000},
    {2'b00, 2'b11, 1'b1, 8'd133, 4'b0000},
    {2'b10, 2'b00, 1'b1, 8'd66,  4'b1000},
    {2'b10, 2'b11, 1'b0, 8'd133, 4'b1000},
    {2'b01, 2'b00, 1'b0, 8'd0,   4'b0100},
    {2'b01, 2'b01, 1'b1, 8'd0,   4'b0001},
    {2'b01, 2'b10, 1'b0, 8'd0,   4'b0110},
    {2'b01, 2'b11, 1'b1, 8'd0,   4'b0110},
    {2'b11, 2'b01, 1'b0, 8'd0,   4'b0110}
  };

  logic       clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0, pg_n = 1'b1;
  logic [1:0] s_lo = 2'b00, s_hi = 2'b00;
  logic       mult_sel = 1'b0, tclk_in = 1'b0;
  logic [1:0] seq_state, lat_s_lo, lat_s_hi;
  logic       outs_on, lat_mult, ext66_sel, tristate_all, reserved_flag;
  logic [7:0] cpu_mhz;
  logic       tck_ref, tck_cpu, tck_48, tck_66, tck_pci;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #80 tclk_in = ~tclk_in;

  clkgen_strap_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pg_n(pg_n),
    .s_lo(s_lo), .s_hi(s_hi), .mult_sel(mult_sel), .tclk_in(tclk_in),
    .seq_state(seq_state), .outs_on(outs_on), .lat_s_lo(lat_s_lo),
    .lat_s_hi(lat_s_hi), .lat_mult(lat_mult), .cpu_mhz(cpu_mhz),
    .ext66_sel(ext66_sel), .tristate_all(tristate_all),
    .reserved_flag(reserved_flag), .tck_ref(tck_ref), .tck_cpu(tck_cpu),
    .tck_48(tck_48), .tck_66(tck_66), .tck_pci(tck_pci)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int exp, input int tol);
    total++;
    if (act < exp - tol || act > exp + tol) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d+-%0d", req, act, exp, tol);
    end
  endtask

  task automatic go_reset();
    rst_n = 1'b0; supply_ok = 1'b0; pg_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // from wait state: raise supply, count settle cycles, stop on arrival at sample state
  task automatic to_sample(output int settle);
    supply_ok = 1'b1;
    settle = 0;
    @(negedge clk);
    while (seq_state == 2'd1 && settle < 1000) begin
      settle++;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int nref, output int ncpu, output int n48,
                         output int n66, output int npci, output int mis);
    logic pr, pc, p4, p6, pp;
    nref = 0; ncpu = 0; n48 = 0; n66 = 0; npci = 0; mis = 0;
    pr = tck_ref; pc = tck_cpu; p4 = tck_48; p6 = tck_66; pp = tck_pci;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (tck_ref && !pr) nref++;
      if (tck_cpu && !pc) ncpu++;
      if (tck_48 && !p4) n48++;
      if (tck_66 && !p6) n66++;
      if (tck_pci && !pp) begin
        npci++;
        if (!(tck_66 && !p6) || !(tck_cpu && !pc)) mis++;
      end
      pr = tck_ref; pc = tck_cpu; p4 = tck_48; p6 = tck_66; pp = tck_pci;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int settle, nr, nc, n4, n6, np, mis;
    logic [16:0] v;

    // R1 reset state
    go_reset();
    chk("R1 state", seq_state, 0);
    chk("R1 outputs", {outs_on, lat_s_lo, lat_s_hi, lat_mult, cpu_mhz, ext66_sel,
        tristate_all, reserved_flag, tck_ref, tck_cpu, tck_48, tck_66, tck_pci}, 0);
    repeat (20) @(negedge clk);
    chk("R2 wait without supply", seq_state, 0);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      s_hi = v[16:15]; s_lo = v[14:13]; mult_sel = v[12];
      go_reset();
      to_sample(settle);
      chk("R2 settle length", settle, SETTLE);
      chk("R2 sample state", seq_state, 2);
      pg_n = 1'b0;
      @(negedge clk);
      chk("R3 running", {seq_state, outs_on}, {2'd3, 1'b1});
      chk("R3 latched", {lat_s_hi, lat_s_lo, lat_mult}, v[16:12]);
      chk("R6 cpu_mhz", cpu_mhz, v[11:4]);
      chk("R7 ext66_sel", ext66_sel, v[3]);
      chk("R8 R9 tristate_all", tristate_all, v[2]);
      chk("R9 reserved_flag", reserved_flag, v[1]);
      measure(nr, nc, n4, n6, np, mis);
      if (v[0]) begin
        chk_near("R10 ref rate", nr, 64, 2);
        chk_near("R10 cpu /2", nc * 2, nr, 2);
        chk_near("R10 48 /2", n4 * 2, nr, 2);
        chk_near("R10 66 /4", n6 * 4, nr, 4);
        chk_near("R10 pci /8", np * 8, nr, 8);
        chk("R11 misaligned pci edges", mis, 0);
      end else begin
        chk("R10 no test clocks", nr + nc + n4 + n6 + np, 0);
      end
    end

    // R3 hold while pg_n high
    s_hi = 2'b00; s_lo = 2'b10; mult_sel = 1'b0;
    go_reset();
    to_sample(settle);
    repeat (10) @(negedge clk);
    chk("R3 hold in sample", {seq_state, outs_on}, {2'd2, 1'b0});
    pg_n = 1'b0;
    @(negedge clk);
    chk("R3 late capture", cpu_mhz, 200);

    // R4 frozen after running
    s_hi = 2'b10; s_lo = 2'b01; mult_sel = 1'b1;
    for (int i = 0; i < 6; i++) begin
      pg_n = ~pg_n;
      repeat (3) @(negedge clk);
    end
    chk("R4 latched frozen", {lat_s_hi, lat_s_lo, lat_mult}, {2'b00, 2'b10, 1'b0});
    chk("R4 decode frozen", {cpu_mhz, ext66_sel, seq_state}, {8'd200, 1'b0, 2'd3});

    // R5 early pg_n ignored
    s_hi = 2'b00; s_lo = 2'b01; mult_sel = 1'b0;
    go_reset();
    pg_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 no early capture", {seq_state, lat_s_lo}, {2'd0, 2'b00});
    supply_ok = 1'b1;
    repeat (2) @(negedge clk);
    s_lo = 2'b11; mult_sel = 1'b1;
    settle = 0;
    while (seq_state == 2'd1 && settle < 1000) begin
      settle++;
      @(negedge clk);
    end
    chk("R5 settle not cut short", settle + 1, SETTLE);
    chk("R5 sample state reached", seq_state, 2);
    @(negedge clk);
    chk("R5 captured in sample", {lat_s_lo, lat_mult, cpu_mhz}, {2'b11, 1'b1, 8'd133});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule